// File: doc/BRIEF.md
# Run-Length Decoded Capture Controller

This block sequences the capture side of a delay-based power-switch test. Switch segments are woken one at a time; for each segment the block picks which observation point feeds the result flop and how many system-clock rising edges to let pass before the result is taken. Both choices come from two small tables stored in run-length form. In the selection table, each entry is a point select paired with the number of consecutive segments that use it. In the timing table, each entry is a skip count paired with the number of consecutive segments that share it. One segment-advance input steps both decoders together, so the select and the skip count always refer to the same segment.

A segment test starts with a start pulse at wake-up. The block loads the current skip count into a down-counter and raises a one-cycle capture strobe when the count runs out. The result flop is enabled only by that strobe, which gates it in the same way a gated clock would, and it stores the selected observation bit. The selection table is fixed by parameter. The timing table resets to a parameter default and can be replaced through a serial shift port, so that calibrated skip counts can be written in after silicon measurement.

Top module: `rl_capture_ctrl`

## Requirements
- R1: Reset is a synchronous active-low reset. After reset, opSel equals the select of selection entry 0 (2 with the default table), capture is low and testResult is 0.
- R2: opSel holds the select of the current selection entry for that entry's run of segments. Each accepted nextSeg pulse uses up one segment of the run, and the decoder then moves to the next entry. After the last entry it wraps to entry 0. Each entry is {select, run length minus one}, and entry i sits at bits [i*W +: W].
- R3: When startSeg is accepted at a rising edge with skip count k, capture is high for exactly the one cycle that follows k further rising edges. With k = 0, it is high right after the accepting edge.
- R4: At the rising edge where capture is high, testResult loads obsIn[opSel]. At every other edge it holds its value.
- R5: The skip count in use comes from the timing table. That table is decoded in lockstep with the selection table by the same nextSeg pulses and wraps the same way. Each entry is {skip count, run length minus one}, and entry i sits at bits [i*W +: W].
- R6: When idle, each cycle with shiftEn high shifts the whole timing table one place toward the MSB and enters shiftBit at bit 0. A full load is therefore MSB first. rewindReq must follow a load before the new run lengths take effect.
- R7: A segment test is in progress from the accepting edge up to and including the capture edge. During that time, startSeg, nextSeg, rewindReq and shiftEn are ignored.
- R8: An accepted rewindReq returns both decoders to entry 0 at the start of its run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| startSeg | input | 1 | Segment wake-up: start the skip countdown |
| nextSeg | input | 1 | Advance both decoders by one segment |
| rewindReq | input | 1 | Return both decoders to entry 0 |
| shiftEn | input | 1 | Shift one bit into the timing table |
| shiftBit | input | 1 | Serial data bit for the timing table |
| obsIn | input | NUM_OBS | Observation point levels |
| opSel | output | SEL_W | Selected observation point |
| capture | output | 1 | One-cycle capture strobe |
| testResult | output | 1 | Stored observation result |

## Verification
The bench walks both decoders past run boundaries and across the wrap from the last entry back to the first. A decoder that miscounted a run, or that held an entry one segment too long or too short, would show the wrong select or the wrong capture delay there. It measures capture timing with skip counts of zero and of the full-scale value, where an off-by-one counter would capture one edge late or would miss capture altogether. It pulses every control input during a countdown and after that checks later segments and the reloaded table, because a design that did not block them would skip a segment or corrupt the skip counts. Last, it reloads the timing table serially and rewinds, which exposes a reversed shift direction or a wrong field order in the timing entries.

// File: rtl/rlcap_pkg.sv
package rlcap_pkg;
  typedef struct packed {
    logic rewind;
    logic advance;
    logic shift;
    logic capture;
  } ctrlStrobes_t;
endpackage

// File: rtl/rl_run_decoder.sv
module rl_run_decoder #(
  parameter int ENTRIES = 4,
  parameter int VAL_W   = 2,
  parameter int RUN_W   = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             rewind,
  input  logic                             advance,
  input  logic [ENTRIES*(VAL_W+RUN_W)-1:0] runTable,
  output logic [VAL_W-1:0]                 curVal
);
  localparam int ENT_W  = VAL_W + RUN_W;
  localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ADDR_W-1:0] addr, nextAddr;
  logic [RUN_W-1:0]  remain;

  function automatic logic [RUN_W-1:0] runOf(input logic [ADDR_W-1:0] idx);
    return runTable[idx*ENT_W +: RUN_W];
  endfunction

  assign nextAddr = (addr == ADDR_W'(ENTRIES - 1)) ? '0 : addr + 1'b1;
  assign curVal   = runTable[addr*ENT_W + RUN_W +: VAL_W];

  always_ff @(posedge clk) begin
    if (!rstN || rewind) begin
      addr   <= '0;
      remain <= runOf('0);
    end else if (advance) begin
      if (remain == '0) begin
        addr   <= nextAddr;
        remain <= runOf(nextAddr);
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

  // R2: entry pointer moves only on an advance or a rewind
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !rewind) |=> $stable(addr));
  // R2: pointer never leaves the table
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    addr <= ADDR_W'(ENTRIES - 1));
  // R8: a rewind lands on entry 0
  a_r8_rewind_zero: assert property (@(posedge clk) disable iff (!rstN)
    rewind |=> (addr == '0));
endmodule

// File: rtl/rl_capture_fsm.sv
module rl_capture_fsm
  import rlcap_pkg::*;
#(
  parameter int SKIP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSeg,
  input  logic              nextSeg,
  input  logic              rewindReq,
  input  logic              shiftEn,
  input  logic [SKIP_W-1:0] skipVal,
  output ctrlStrobes_t      strobes,
  output logic              capture
);
  logic              busy;
  logic [SKIP_W-1:0] cnt;
  logic              startOk;

  assign startOk = startSeg && !busy;
  assign capture = busy && (cnt == '0);

  always_comb begin
    strobes.rewind  = rewindReq && !busy;
    strobes.advance = nextSeg && !busy && !rewindReq;
    strobes.shift   = shiftEn && !busy;
    strobes.capture = capture;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (startOk) begin
      busy <= 1'b1;
      cnt  <= skipVal;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R3: capture is a single-cycle strobe
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> !capture);
  // R3: zero skip captures right after the wake-up edge
  a_r3_zero_skip: assert property (@(posedge clk) disable iff (!rstN)
    (startOk && skipVal == '0) |=> capture);
  // R3: nonzero skip does not capture immediately
  a_r3_nonzero_wait: assert property (@(posedge clk) disable iff (!rstN)
    (startOk && skipVal != '0) |=> !capture);
  // R7: a running test stays running until its capture
  a_r7_busy_until_capture: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !capture) |=> busy);
endmodule

// File: rtl/rl_capture_dp.sv
module rl_capture_dp
  import rlcap_pkg::*;
#(
  parameter int NUM_OBS    = 4,
  parameter int SEL_W      = 2,
  parameter int SKIP_W     = 4,
  parameter int RUN_W      = 4,
  parameter int OP_ENTRIES = 4,
  parameter int C_ENTRIES  = 4,
  parameter logic [OP_ENTRIES*(SEL_W+RUN_W)-1:0] OP_TABLE  = '0,
  parameter logic [C_ENTRIES*(SKIP_W+RUN_W)-1:0] C_DEFAULT = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic               shiftBit,
  input  logic [NUM_OBS-1:0] obsIn,
  output logic [SEL_W-1:0]   opSel,
  output logic [SKIP_W-1:0]  skipVal,
  output logic               testResult
);
  localparam int C_BITS = C_ENTRIES * (SKIP_W + RUN_W);

  logic [C_BITS-1:0] cTable;

  always_ff @(posedge clk) begin
    if (!rstN)              cTable <= C_DEFAULT;
    else if (strobes.shift) cTable <= {cTable[C_BITS-2:0], shiftBit};
  end

  rl_run_decoder #(.ENTRIES(OP_ENTRIES), .VAL_W(SEL_W), .RUN_W(RUN_W)) u_opDec (
    .clk(clk), .rstN(rstN), .rewind(strobes.rewind), .advance(strobes.advance),
    .runTable(OP_TABLE), .curVal(opSel)
  );

  rl_run_decoder #(.ENTRIES(C_ENTRIES), .VAL_W(SKIP_W), .RUN_W(RUN_W)) u_skipDec (
    .clk(clk), .rstN(rstN), .rewind(strobes.rewind), .advance(strobes.advance),
    .runTable(cTable), .curVal(skipVal)
  );

  always_ff @(posedge clk) begin
    if (!rstN)                testResult <= 1'b0;
    else if (strobes.capture) testResult <= obsIn[opSel];
  end

  // R6: timing table changes only through an accepted shift
  a_r6_table_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shift |=> $stable(cTable));
  // R4: result flop is closed while capture is low
  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(testResult));
endmodule

// File: rtl/rl_capture_ctrl.sv
module rl_capture_ctrl
  import rlcap_pkg::*;
#(
  parameter int NUM_OBS    = 4,
  parameter int NUM_SEG    = 16,
  parameter int SKIP_W     = 4,
  parameter int OP_ENTRIES = 4,
  parameter int C_ENTRIES  = 4,
  parameter logic [OP_ENTRIES*($clog2(NUM_OBS)+$clog2(NUM_SEG))-1:0] OP_TABLE =
    24'b010001_110011_000000_100010,
  parameter logic [C_ENTRIES*(SKIP_W+$clog2(NUM_SEG))-1:0] C_DEFAULT = 32'h1352_0031
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startSeg,
  input  logic                        nextSeg,
  input  logic                        rewindReq,
  input  logic                        shiftEn,
  input  logic                        shiftBit,
  input  logic [NUM_OBS-1:0]          obsIn,
  output logic [$clog2(NUM_OBS)-1:0]  opSel,
  output logic                        capture,
  output logic                        testResult
);
  localparam int SEL_W = $clog2(NUM_OBS);
  localparam int RUN_W = $clog2(NUM_SEG);

  ctrlStrobes_t      strobes;
  logic [SKIP_W-1:0] skipVal;

  rl_capture_fsm #(.SKIP_W(SKIP_W)) u_fsm (
    .clk(clk), .rstN(rstN), .startSeg(startSeg), .nextSeg(nextSeg),
    .rewindReq(rewindReq), .shiftEn(shiftEn), .skipVal(skipVal),
    .strobes(strobes), .capture(capture)
  );

  rl_capture_dp #(
    .NUM_OBS(NUM_OBS), .SEL_W(SEL_W), .SKIP_W(SKIP_W), .RUN_W(RUN_W),
    .OP_ENTRIES(OP_ENTRIES), .C_ENTRIES(C_ENTRIES),
    .OP_TABLE(OP_TABLE), .C_DEFAULT(C_DEFAULT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .shiftBit(shiftBit),
    .obsIn(obsIn), .opSel(opSel), .skipVal(skipVal), .testResult(testResult)
  );
endmodule

// File: tb/rl_capture_ctrl_tb.sv
`timescale 1ns/1ps
module rl_capture_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startSeg = 1'b0, nextSeg = 1'b0, rewindReq = 1'b0;
  logic       shiftEn = 1'b0, shiftBit = 1'b0;
  logic [3:0] obsIn = '0;
  logic [1:0] opSel;
  logic       capture, testResult;

  rl_capture_ctrl u_dut (
    .clk(clk), .rstN(rstN), .startSeg(startSeg), .nextSeg(nextSeg),
    .rewindReq(rewindReq), .shiftEn(shiftEn), .shiftBit(shiftBit),
    .obsIn(obsIn), .opSel(opSel), .capture(capture), .testResult(testResult)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    sel;
    int    skip;
    bit    res;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t pendExp;
  bit       pending = 1'b0;
  int       nChecks = 0, nFail = 0, doneCnt = 0;
  int       cycleCnt = 0, startCyc = 0;
  bit       finished = 1'b0;

  // Expected tables in run form (select/skip, run length)
  int opV[4] = '{2, 0, 3, 1};
  int opL[4] = '{3, 1, 4, 2};
  int cV[4]  = '{3, 0, 5, 1};
  int cL[4]  = '{2, 1, 3, 4};
  int nV[4]  = '{7, 2, 15, 0};
  int nL[4]  = '{1, 5, 1, 3};

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int rlLookup(input int v[4], input int l[4], input int seg);
    int total = 0;
    int s;
    for (int i = 0; i < 4; i++) total += l[i];
    s = seg % total;
    for (int i = 0; i < 4; i++) begin
      if (s < l[i]) return v[i];
      s -= l[i];
    end
    return -1;
  endfunction

  // Monitor: pops one expected item per capture strobe
  always @(negedge clk) begin
    if (rstN) begin
      if (pending) begin
        chk(testResult == pendExp.res, {pendExp.tag, " R4 result"}, testResult, pendExp.res);
        pending = 1'b0;
        doneCnt++;
      end
      if (capture) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 unexpected capture", 1, 0);
        end else begin
          pendExp = expQ.pop_front();
          chk(opSel == 2'(pendExp.sel), {pendExp.tag, " R2 opSel"}, opSel, pendExp.sel);
          chk((cycleCnt - startCyc) == pendExp.skip, {pendExp.tag, " R3 R5 skip delay"},
              cycleCnt - startCyc, pendExp.skip);
          pending = 1'b1;
        end
      end
    end
  end

  task automatic pulseNext();
    @(negedge clk) nextSeg = 1'b1;
    @(negedge clk) nextSeg = 1'b0;
  endtask

  task automatic runSeg(input int sel, input int skip, input bit disturb, input bit hi,
                        input string tag);
    expItem_t it;
    int d0;
    int guard;
    it.sel = sel; it.skip = skip; it.res = hi; it.tag = tag;
    @(negedge clk);
    obsIn = hi ? (4'b1 << sel) : ~(4'b1 << sel);
    expQ.push_back(it);
    d0 = doneCnt;
    startSeg = 1'b1;
    startCyc = cycleCnt + 1;
    @(negedge clk) startSeg = 1'b0;
    if (disturb) begin
      // R7: every control input pulsed while the countdown runs
      startSeg = 1'b1; nextSeg = 1'b1; rewindReq = 1'b1; shiftEn = 1'b1; shiftBit = 1'b1;
      @(negedge clk);
      startSeg = 1'b0; nextSeg = 1'b0; rewindReq = 1'b0; shiftEn = 1'b0;
    end
    guard = 0;
    while (doneCnt == d0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 100, {tag, " R3 capture seen"}, guard, 0);
  endtask

  task automatic doRewind(input string tag);
    @(negedge clk) rewindReq = 1'b1;
    @(negedge clk) rewindReq = 1'b0;
    chk(opSel == 2'd2, {tag, " R8 opSel after rewind"}, opSel, 2);
  endtask

  initial begin
    logic [31:0] newC;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(opSel == 2'd2, "R1 reset opSel", opSel, 2);
    chk(capture == 1'b0, "R1 reset capture", capture, 0);
    chk(testResult == 1'b0, "R1 reset result", testResult, 0);

    // R2 R5: walk default tables past every run boundary and the wrap
    for (int s = 0; s < 12; s++) begin
      runSeg(rlLookup(opV, opL, s), rlLookup(cV, cL, s), (s == 3 || s == 6),
             s[0], (s == 3 || s == 6) ? "R7 busy" : "R2 walk");
      pulseNext();
    end

    // R8: rewind mid-run, then segment 0 again with its skip count
    doRewind("R8");
    runSeg(rlLookup(opV, opL, 0), rlLookup(cV, cL, 0), 1'b0, 1'b1, "R8 skip rewind");

    // R6: serial reload, MSB first, entry {skip, run-1}
    newC = '0;
    for (int i = 0; i < 4; i++) newC[i*8 +: 8] = {4'(nV[i]), 4'(nL[i] - 1)};
    for (int b = 31; b >= 0; b--) begin
      @(negedge clk);
      shiftEn = 1'b1;
      shiftBit = newC[b];
    end
    @(negedge clk) shiftEn = 1'b0;
    doRewind("R6");
    for (int s = 0; s < 11; s++) begin
      runSeg(rlLookup(opV, opL, s), rlLookup(nV, nL, s), (s == 1), ~s[0],
             (s == 1) ? "R7 R6 busy" : "R6 reload");
      pulseNext();
    end

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R3 all captures seen", expQ.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog R3", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule